// File: doc/BRIEF.md
# Video Display Address Generator

This block produces the memory address from which the display pipeline fetches its next 16-bit word of bitmap data. Software sets the screen origin by writing a base address one byte at a time into three registers (high, middle, low). The base is not used right away. It is copied into a running address counter only when the video timing generator signals the start of a frame. Because of this, software can prepare the next frame's origin at any time without disturbing the picture being drawn.

During a frame, each fetch strobe moves the counter forward by one word. Each line-end strobe adds a programmable number of extra words to the counter. With that skip value set to zero, the screen is one contiguous bitmap of 32,000 bytes with the planes interleaved word by word. With a non-zero skip value, the visible screen becomes a window onto a wider virtual bitmap. The live counter can be read back by the CPU byte by byte.

The control core has two states. `ST_IDLE` is entered at reset: the counter holds and every strobe except frame start is ignored. A frame start moves it to `ST_SCAN` (transition *arm*). In `ST_SCAN`, a frame start reloads the counter (transition *reload*). Otherwise fetch and line-end strobes advance the counter and the state does not change (transition *advance*). Nothing leads back to `ST_IDLE` except reset.

Top module: `vid_addr_gen`

## Requirements
- R1: After reset, `fetch_addr` is 0 and every readable register returns 0.
- R2: A write with `cpu_we` high stores `cpu_wdata` at the next edge. Select 0 is base high (bits 23:16), 1 is base middle (15:8), 2 is base low (7:0), 6 is the extra-line-width value in words. Bit 0 of base low is always stored and read as 0.
- R3: Writes to the base registers never change `fetch_addr`.
- R4: On the edge after `frame_start`, `fetch_addr` equals the base value held before that edge. A base write in that same cycle affects only the next frame.
- R5: In `ST_SCAN`, a `fetch_stb` without other strobes makes `fetch_addr` larger by 2 on the next edge.
- R6: In `ST_SCAN`, a `line_end` adds twice the extra-line-width value to `fetch_addr` on the next edge. A value of 0 leaves scanning contiguous. When `line_end` and `fetch_stb` arrive together, the increase is 2 plus twice the extra-line-width value.
- R7: `frame_start` takes priority over `line_end` and `fetch_stb` in the same cycle.
- R8: Before the first `frame_start` after reset (`ST_IDLE`), `fetch_stb` and `line_end` have no effect on `fetch_addr`.
- R9: `cpu_rdata` reflects `cpu_rsel` combinationally. Selects 3, 4 and 5 return the live counter bytes (high, middle, low), and select 7 returns 0. Writes to selects 3, 4, 5 and 7 change nothing.
- R10: Counter arithmetic wraps modulo 2^24.
- R11: Bit 0 of `fetch_addr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe from video timing |
| line_end | input | 1 | End-of-display-line strobe |
| fetch_stb | input | 1 | One display word fetched |
| cpu_we | input | 1 | CPU register write enable |
| cpu_wsel | input | 3 | CPU write register select |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rsel | input | 3 | CPU read register select |
| cpu_rdata | output | 8 | CPU read data |
| fetch_addr | output | 24 | Current byte address of display fetch |

## Verification
The bench builds the block with its defaults: a 24-bit address formed from three base bytes and an 8-bit extra-line-width register. With these values, a base of 0xFFFFFE followed by fetches and large line skips reaches the wrap at 2^24. Skip values up to 255 let a single line end move the counter by 510 bytes. Directed sequences cover a base write in the same cycle as a frame start, and all strobes asserted together. A long random phase then mixes CPU writes with strobes, with frame starts kept rare so that long scans build up between reloads.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } vag_state_e;

    typedef struct packed {
        logic frame;
        logic line;
        logic fetch;
    } vag_strobe_t;

endpackage

// File: rtl/vag_regs.sv
module vag_regs #(
    parameter int BASE_BYTES = 3,
    parameter int XLW_W      = 8,
    parameter int SEL_W      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [7:0]                wr_data,
    output logic [8*BASE_BYTES-1:0]   base_addr,
    output logic [XLW_W-1:0]          xlw
);
    localparam int ADDR_W  = 8 * BASE_BYTES;
    localparam int XLW_SEL = 2 * BASE_BYTES;

    for (genvar i = 0; i < BASE_BYTES; i++) begin : g_base
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                byte_q <= wr_data;
            end
        end
        if (i == BASE_BYTES - 1) begin : g_low
            assign base_addr[7:0] = {byte_q[7:1], 1'b0};
        end else begin : g_upper
            assign base_addr[ADDR_W-1-8*i -: 8] = byte_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlw <= '0;
        end else if (wr_en && wr_sel == SEL_W'(XLW_SEL)) begin
            xlw <= wr_data[XLW_W-1:0];
        end
    end

endmodule

// File: rtl/vag_counter.sv
module vag_counter
    import vag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int XLW_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  vag_strobe_t         stb,
    input  logic [ADDR_W-2:0]   base_word,
    input  logic [XLW_W-1:0]    xlw,
    output logic [ADDR_W-1:0]   cnt,
    output logic                scanning
);
    localparam int WW = ADDR_W - 1;

    vag_state_e      state_q, state_d;
    logic [WW-1:0]   word_q, word_d;
    logic [WW-1:0]   step;

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    // Next state and counter value
    always_comb begin
        step    = WW'(stb.fetch) + (stb.line ? WW'(xlw) : '0);
        state_d = state_q;
        word_d  = word_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stb.frame) begin
                    state_d = ST_SCAN;
                    word_d  = base_word;
                end
            end
            ST_SCAN: begin
                if (stb.frame) begin
                    word_d = base_word;
                end else begin
                    word_d = word_q + step;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign cnt      = {word_q, 1'b0};
    assign scanning = (state_q == ST_SCAN);

endmodule

// File: rtl/vag_readmux.sv
module vag_readmux #(
    parameter int BASE_BYTES = 3,
    parameter int XLW_W      = 8,
    parameter int SEL_W      = 3
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [8*BASE_BYTES-1:0]   base_addr,
    input  logic [8*BASE_BYTES-1:0]   cnt,
    input  logic [XLW_W-1:0]          xlw,
    output logic [7:0]                rdata
);
    localparam int ADDR_W  = 8 * BASE_BYTES;
    localparam int XLW_SEL = 2 * BASE_BYTES;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < BASE_BYTES; i++) begin
            if (sel == SEL_W'(i)) begin
                rdata = base_addr[ADDR_W-1-8*i -: 8];
            end
            if (sel == SEL_W'(BASE_BYTES + i)) begin
                rdata = cnt[ADDR_W-1-8*i -: 8];
            end
        end
        if (sel == SEL_W'(XLW_SEL)) begin
            rdata = 8'(xlw);
        end
    end

endmodule

// File: rtl/vid_addr_gen.sv
module vid_addr_gen
    import vag_pkg::*;
#(
    parameter int BASE_BYTES = 3,
    parameter int XLW_W      = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    frame_start,
    input  logic                                    line_end,
    input  logic                                    fetch_stb,
    input  logic                                    cpu_we,
    input  logic [$clog2(2*BASE_BYTES+1)-1:0]       cpu_wsel,
    input  logic [7:0]                              cpu_wdata,
    input  logic [$clog2(2*BASE_BYTES+1)-1:0]       cpu_rsel,
    output logic [7:0]                              cpu_rdata,
    output logic [8*BASE_BYTES-1:0]                 fetch_addr
);
    localparam int ADDR_W = 8 * BASE_BYTES;
    localparam int SEL_W  = $clog2(2*BASE_BYTES+1);

    logic [ADDR_W-1:0] base_addr;
    logic [XLW_W-1:0]  xlw;
    logic              scanning;
    vag_strobe_t       stb;

    assign stb = '{frame: frame_start, line: line_end, fetch: fetch_stb};

    vag_regs #(.BASE_BYTES(BASE_BYTES), .XLW_W(XLW_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_we),
        .wr_sel    (cpu_wsel),
        .wr_data   (cpu_wdata),
        .base_addr (base_addr),
        .xlw       (xlw)
    );

    vag_counter #(.ADDR_W(ADDR_W), .XLW_W(XLW_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .base_word (base_addr[ADDR_W-1:1]),
        .xlw       (xlw),
        .cnt       (fetch_addr),
        .scanning  (scanning)
    );

    vag_readmux #(.BASE_BYTES(BASE_BYTES), .XLW_W(XLW_W), .SEL_W(SEL_W)) u_rd (
        .sel       (cpu_rsel),
        .base_addr (base_addr),
        .cnt       (fetch_addr),
        .xlw       (xlw),
        .rdata     (cpu_rdata)
    );

endmodule

// File: rtl/vid_addr_gen_chk.sv
module vid_addr_gen_chk #(
    parameter int ADDR_W = 24,
    parameter int XLW_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_end,
    input logic              fetch_stb,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] base_addr,
    input logic [XLW_W-1:0]  xlw,
    input logic              scanning
);
    assert_addr_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[0] == 1'b0);

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> fetch_addr == $past(base_addr));

    assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && fetch_stb && !line_end && !frame_start)
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

    assert_line_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && line_end && !fetch_stb && !frame_start)
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'({xlw, 1'b0}));

    assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_end && !fetch_stb) |=> $stable(fetch_addr));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && !frame_start) |=> $stable(fetch_addr));

endmodule

bind vid_addr_gen vid_addr_gen_chk #(.ADDR_W(8*BASE_BYTES), .XLW_W(XLW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_end    (line_end),
    .fetch_stb   (fetch_stb),
    .fetch_addr  (fetch_addr),
    .base_addr   (base_addr),
    .xlw         (xlw),
    .scanning    (scanning)
);

// File: tb/vid_addr_gen_test.sv
module vid_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_end = 1'b0;
    logic        fetch_stb = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_wsel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [2:0]  cpu_rsel = '0;
    logic [7:0]  cpu_rdata;
    logic [23:0] fetch_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    int m_base[3];
    int m_cnt;
    int m_xlw;
    bit m_scan;

    always #5 clk = ~clk;

    vid_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .fetch_stb(fetch_stb), .cpu_we(cpu_we), .cpu_wsel(cpu_wsel),
        .cpu_wdata(cpu_wdata), .cpu_rsel(cpu_rsel), .cpu_rdata(cpu_rdata),
        .fetch_addr(fetch_addr)
    );

    function automatic int model_read(int sel);
        case (sel)
            0, 1, 2: return m_base[sel];
            3:       return (m_cnt >> 16) & 255;
            4:       return (m_cnt >> 8) & 255;
            5:       return m_cnt & 255;
            6:       return m_xlw;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(string req, bit fs, bit le, bit fe, bit we,
                       int wsel, int wdata, int rsel);
        int nxt;
        frame_start = fs; line_end = le; fetch_stb = fe;
        cpu_we = we; cpu_wsel = 3'(wsel); cpu_wdata = 8'(wdata); cpu_rsel = 3'(rsel);
        @(posedge clk);
        nxt = m_cnt;
        if (fs) nxt = (m_base[0] << 16) | (m_base[1] << 8) | m_base[2];
        else if (m_scan) nxt = (m_cnt + (fe ? 2 : 0) + (le ? 2 * m_xlw : 0)) & 24'hFFFFFF;
        m_cnt = nxt;
        if (fs) m_scan = 1'b1;
        if (we) begin
            if (wsel == 2) m_base[2] = wdata & 8'hFE;
            else if (wsel < 2) m_base[wsel] = wdata;
            else if (wsel == 6) m_xlw = wdata;
        end
        @(negedge clk);
        check(req, int'(fetch_addr), m_cnt);
        check(req, int'(cpu_rdata), model_read(rsel));
    endtask

    task automatic wr(string req, int sel, int data);
        cyc(req, 0, 0, 0, 1, sel, data, sel);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_base = '{0, 0, 0}; m_cnt = 0; m_xlw = 0; m_scan = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values on every select
        for (int s = 0; s < 8; s++) cyc("R1", 0, 0, 0, 0, 0, 0, s);
        // R8: strobes before the first frame start are ignored
        cyc("R8", 0, 0, 1, 0, 0, 0, 5);
        cyc("R8", 0, 1, 1, 0, 0, 0, 5);
        wr("R8", 6, 3);
        cyc("R8", 0, 1, 0, 0, 0, 0, 4);
        // R2/R3: base writes, low bit reads 0, counter untouched
        wr("R2", 0, 8'h12);
        wr("R2", 1, 8'h34);
        wr("R3", 2, 8'h57);
        cyc("R2", 0, 0, 0, 0, 0, 0, 2);
        wr("R6", 6, 0);
        // R4: reload at frame start
        cyc("R4", 1, 0, 0, 0, 0, 0, 5);
        // R5: fetch steps, R9 live counter read
        for (int k = 0; k < 4; k++) cyc("R5", 0, 0, 1, 0, 0, 0, 5);
        cyc("R9", 0, 0, 1, 0, 0, 0, 4);
        // R6: line end with zero, then non-zero skip, then both strobes
        cyc("R6", 0, 1, 0, 0, 0, 0, 5);
        wr("R6", 6, 5);
        cyc("R6", 0, 1, 0, 0, 0, 0, 5);
        cyc("R6", 0, 1, 1, 0, 0, 0, 5);
        // R3: base write mid-frame does not disturb counter
        wr("R3", 0, 8'h40);
        cyc("R3", 0, 0, 1, 1, 1, 8'h00, 3);
        // R4: base write in the same cycle as frame start uses old base
        cyc("R4", 1, 0, 0, 1, 2, 8'h22, 5);
        cyc("R4", 1, 0, 0, 0, 0, 0, 5);
        // R7: frame start beats line end and fetch
        cyc("R7", 1, 1, 1, 0, 0, 0, 5);
        // R9: counter and unmapped selects ignore writes
        wr("R9", 4, 8'hAA);
        wr("R9", 7, 8'h55);
        cyc("R9", 0, 0, 0, 0, 0, 0, 7);
        // R10: wrap past the top of the address space
        wr("R10", 0, 8'hFF); wr("R10", 1, 8'hFF); wr("R10", 2, 8'hFF);
        cyc("R10", 1, 0, 0, 0, 0, 0, 3);
        cyc("R10", 0, 0, 1, 0, 0, 0, 3);
        wr("R10", 6, 8'hFF);
        cyc("R10", 1, 0, 0, 0, 0, 0, 3);
        cyc("R10", 0, 1, 1, 0, 0, 0, 3);
        // Random mix, R11 bit 0 checked on each cycle
        for (int k = 0; k < 3000; k++) begin
            cyc("R11", ($urandom % 200) == 0, ($urandom % 16) == 0, ($urandom % 3) != 0,
                ($urandom % 10) == 0, $urandom % 8, $urandom % 256, $urandom % 8);
            check("R11", int'(fetch_addr[0]), 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule